// File: doc/BRIEF.md
# Machine-Mode Interrupt Arbiter with Trap Entry

This block gathers the level-sensitive interrupt request lines of a processor core into one 32-bit pending vector. It qualifies each maskable request with its enable bit and with the global interrupt enable, and picks the single request with the highest bit index. When a request is accepted, the block issues a one-cycle trap pulse. In the same cycle it updates the cause word and the machine status fields: the global enable, the previous-enable field and the previous-privilege field.

The non-maskable request sits in the top bit of the vector. It bypasses both the enable register and the global enable, and it never appears in the pending or enable views. A return-from-trap strobe restores the global enable from the previous-enable field. A separate set-enable strobe lets software turn interrupts back on. The surrounding core drives the request lines, the enable register and the two strobes, and it reacts to the trap pulse and the cause word.

Top module: `mtrap_arbiter`

## Requirements
- R1: `pendingReg` is a register that copies the live request levels on every clock edge, so it shows them one cycle later and latches no edges. The software request is at bit 3, the timer at bit 7, the external request at bit 11 and fast line i at bit 16+i (bits 16..30). Every other bit reads 0.
- R2: Bit 31 of `pendingReg` and of `enableView` always reads 0. `enableView` equals `enableIn` with bit 31 forced to 0.
- R3: When several qualified requests are present, the one at the highest bit index wins. The non-maskable request counts as bit 31.
- R4: A maskable request at bit i is taken only while `enableIn[i]` is 1. A request whose enable bit is clear causes no trap.
- R5: A maskable request is taken only while `gieOut` is 1. The non-maskable request is taken even while `gieOut` is 0.
- R6: On the trap pulse, `causeWord[31]` is 1, bits 30..5 are 0 and bits 4..0 hold the winning bit index. The cause word keeps this value until the next trap or reset.
- R7: In the cycle `takeTrap` is high, `gieOut` is 0, `pieOut` is 1 and `privPrevOut` is 2'b11.
- R8: `takeTrap` is high for exactly one cycle, two clock edges after the winning request line is driven. No further trap is taken until the global enable is set again by `setGie` or by a return, even while a line stays high.
- R9: On a `retStrobe` edge, `gieOut` takes the old `pieOut` value and `pieOut` becomes 1. No trap is taken on that edge; it can follow on the next edge.
- R10: A `setGie` edge with no return and no trap sets `gieOut` to 1 and re-arms trap acceptance.
- R11: A synchronous active-low reset clears `gieOut`, `pieOut`, `causeWord`, `takeTrap` and `pendingReg`, and sets `privPrevOut` to 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| swReq | input | 1 | Software interrupt level |
| timerReq | input | 1 | Timer interrupt level |
| extReq | input | 1 | External interrupt level |
| fastReq | input | 15 | Fast interrupt levels, line i maps to bit 16+i |
| nmiReq | input | 1 | Non-maskable interrupt level |
| enableIn | input | 32 | Per-bit interrupt enable register |
| setGie | input | 1 | Strobe that sets the global enable |
| retStrobe | input | 1 | Return-from-trap strobe |
| takeTrap | output | 1 | One-cycle trap-entry pulse |
| causeWord | output | 32 | Trap cause: interrupt flag and winning index |
| pendingReg | output | 32 | Registered pending vector |
| enableView | output | 32 | Enable register as seen, bit 31 zero |
| gieOut | output | 1 | Global interrupt enable |
| pieOut | output | 1 | Previous interrupt enable |
| privPrevOut | output | 2 | Previous privilege field |

## Verification
Directed patterns come first. Three lines are raised together with one fast line to show that the highest index wins over lower ones. The enable register is then cut down to the two low sources, which shows that masking changes the winner and does not just block the trap. The non-maskable line is raised while the global enable is still 0 after reset; set against a masked external request, this separates the global-enable bypass from the global-enable gate. A line is held high across the trap, and a return strobe is placed on the edge where a trap would fire, which separates the re-entry guard from the return priority. A long random phase with sparse lines, random enables and random strobes is then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = $clog2(XLEN);

  // Strobes from the arbitration control to the status datapath
  typedef struct packed {
    logic              take;
    logic              ret;
    logic              setGie;
    logic [IDX_W-1:0]  winIdx;
  } trapStrobes_t;
endpackage

// File: rtl/irq_sample_dp.sv
module irq_sample_dp
  import mtrap_pkg::*;
#(
  parameter int SW_BIT    = 3,
  parameter int TIMER_BIT = 7,
  parameter int EXT_BIT   = 11,
  parameter int FAST_BASE = 16,
  parameter int NUM_FAST  = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReq,
  input  logic                timerReq,
  input  logic                extReq,
  input  logic [NUM_FAST-1:0] fastReq,
  input  logic                nmiReq,
  output logic [XLEN-1:0]     reqQ
);
  logic [XLEN-1:0] liveVec;

  always_comb begin
    liveVec            = '0;
    liveVec[SW_BIT]    = swReq;
    liveVec[TIMER_BIT] = timerReq;
    liveVec[EXT_BIT]   = extReq;
    for (int i = 0; i < NUM_FAST; i++) begin
      liveVec[FAST_BASE + i] = fastReq[i];
    end
    liveVec[XLEN-1]    = nmiReq;
  end

  // Level follower: a fresh copy every cycle, no edge latching
  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= liveVec;
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import mtrap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [XLEN-1:0]   reqQ,
  input  logic [XLEN-2:0]   enableLow,
  input  logic              gie,
  input  logic              pie,
  input  logic              retStrobe,
  input  logic              setGie,
  output trapStrobes_t      strobes
);
  logic [XLEN-1:0]  candMask;
  logic [IDX_W-1:0] winIdx;
  logic             anyCand;
  logic             inHandler;
  logic             takeNow;

  assign candMask = {reqQ[XLEN-1], reqQ[XLEN-2:0] & enableLow & {(XLEN-1){gie}}};
  assign anyCand  = |candMask;

  // Ascending scan: the last set bit, i.e. the highest index, wins
  always_comb begin
    winIdx = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (candMask[i]) winIdx = IDX_W'(i);
    end
  end

  // A return owns its edge; a trap can follow on the next one
  assign takeNow = anyCand && !inHandler && !retStrobe;

  always_ff @(posedge clk) begin
    if (!rstN)                              inHandler <= 1'b0;
    else if (takeNow)                       inHandler <= 1'b1;
    else if (retStrobe && pie)              inHandler <= 1'b0;
    else if (setGie && !retStrobe)          inHandler <= 1'b0;
  end

  always_comb begin
    strobes.take   = takeNow;
    strobes.ret    = retStrobe;
    strobes.setGie = setGie && !retStrobe && !takeNow;
    strobes.winIdx = winIdx;
  end
endmodule

// File: rtl/trap_status_dp.sv
module trap_status_dp
  import mtrap_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobes_t    strobes,
  output logic            takeTrap,
  output logic [XLEN-1:0] causeWord,
  output logic            gie,
  output logic            pie,
  output logic [1:0]      privPrev
);
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeTrap  <= 1'b0;
      causeWord <= '0;
      gie       <= 1'b0;
      pie       <= 1'b0;
      privPrev  <= PRIV_MACHINE;
    end else if (strobes.take) begin
      takeTrap  <= 1'b1;
      causeWord <= {1'b1, {(XLEN-1-IDX_W){1'b0}}, strobes.winIdx};
      gie       <= 1'b0;
      pie       <= 1'b1;
      privPrev  <= PRIV_MACHINE;
    end else begin
      takeTrap <= 1'b0;
      if (strobes.ret) begin
        gie <= pie;
        pie <= 1'b1;
      end else if (strobes.setGie) begin
        gie <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtrap_arbiter.sv
module mtrap_arbiter
  import mtrap_pkg::*;
#(
  parameter int SW_BIT    = 3,
  parameter int TIMER_BIT = 7,
  parameter int EXT_BIT   = 11,
  parameter int FAST_BASE = 16,
  parameter int NUM_FAST  = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swReq,
  input  logic                timerReq,
  input  logic                extReq,
  input  logic [NUM_FAST-1:0] fastReq,
  input  logic                nmiReq,
  input  logic [XLEN-1:0]     enableIn,
  input  logic                setGie,
  input  logic                retStrobe,
  output logic                takeTrap,
  output logic [XLEN-1:0]     causeWord,
  output logic [XLEN-1:0]     pendingReg,
  output logic [XLEN-1:0]     enableView,
  output logic                gieOut,
  output logic                pieOut,
  output logic [1:0]          privPrevOut
);
  logic [XLEN-1:0] reqQ;
  trapStrobes_t    strobes;

  irq_sample_dp #(
    .SW_BIT(SW_BIT), .TIMER_BIT(TIMER_BIT), .EXT_BIT(EXT_BIT),
    .FAST_BASE(FAST_BASE), .NUM_FAST(NUM_FAST)
  ) uSample (
    .clk(clk), .rstN(rstN), .swReq(swReq), .timerReq(timerReq),
    .extReq(extReq), .fastReq(fastReq), .nmiReq(nmiReq), .reqQ(reqQ)
  );

  trap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqQ(reqQ), .enableLow(enableIn[XLEN-2:0]),
    .gie(gieOut), .pie(pieOut), .retStrobe(retStrobe), .setGie(setGie),
    .strobes(strobes)
  );

  trap_status_dp uStatus (
    .clk(clk), .rstN(rstN), .strobes(strobes), .takeTrap(takeTrap),
    .causeWord(causeWord), .gie(gieOut), .pie(pieOut), .privPrev(privPrevOut)
  );

  // The non-maskable line owns no enable and no pending bit
  assign pendingReg = {1'b0, reqQ[XLEN-2:0]};
  assign enableView = {1'b0, enableIn[XLEN-2:0]};
endmodule

// File: rtl/mtrap_arbiter_chk.sv
module mtrap_arbiter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        swReq,
  input logic        timerReq,
  input logic        extReq,
  input logic [14:0] fastReq,
  input logic        setGie,
  input logic        retStrobe,
  input logic        takeTrap,
  input logic [31:0] causeWord,
  input logic [31:0] pendingReg,
  input logic [31:0] enableView,
  input logic        gieOut,
  input logic        pieOut,
  input logic [1:0]  privPrevOut
);
  AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> pendingReg[3] == $past(swReq) && pendingReg[7] == $past(timerReq) &&
             pendingReg[11] == $past(extReq) && pendingReg[30:16] == $past(fastReq)); // R1

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !pendingReg[31] && !enableView[31]); // R2

  AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap && causeWord[4:0] != 5'd31 |->
      ($past(pendingReg & enableView) >> causeWord[4:0]) == 32'd1); // R3

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap && causeWord[4:0] != 5'd31 |-> $past(gieOut)); // R5

  AST_CAUSE_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |-> causeWord[31] && causeWord[30:5] == 26'd0); // R6

  AST_ENTRY_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |-> !gieOut && pieOut && privPrevOut == 2'b11); // R7

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |=> !takeTrap); // R8

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |=> gieOut == $past(pieOut) && pieOut && !takeTrap); // R9

  AST_SET_GIE: assert property (@(posedge clk) disable iff (!rstN)
    setGie && !retStrobe |=> gieOut || takeTrap); // R10

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !gieOut && !pieOut && privPrevOut == 2'b11 &&
                     causeWord == 32'd0 && !takeTrap); // R11
endmodule

bind mtrap_arbiter mtrap_arbiter_chk uChk (
  .clk(clk), .rstN(rstN), .swReq(swReq), .timerReq(timerReq), .extReq(extReq),
  .fastReq(fastReq), .setGie(setGie), .retStrobe(retStrobe), .takeTrap(takeTrap),
  .causeWord(causeWord), .pendingReg(pendingReg), .enableView(enableView),
  .gieOut(gieOut), .pieOut(pieOut), .privPrevOut(privPrevOut)
);

// File: tb/sim_mtrap_arbiter.sv
`timescale 1ns/1ps
module sim_mtrap_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReq = 1'b0, timerReq = 1'b0, extReq = 1'b0, nmiReq = 1'b0;
  logic [14:0] fastReq = '0;
  logic [31:0] enableIn = '0;
  logic        setGie = 1'b0, retStrobe = 1'b0;
  logic        takeTrap, gieOut, pieOut;
  logic [31:0] causeWord, pendingReg, enableView;
  logic [1:0]  privPrevOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  mtrap_arbiter u0 (
    .clk(clk), .rstN(rstN), .swReq(swReq), .timerReq(timerReq), .extReq(extReq),
    .fastReq(fastReq), .nmiReq(nmiReq), .enableIn(enableIn), .setGie(setGie),
    .retStrobe(retStrobe), .takeTrap(takeTrap), .causeWord(causeWord),
    .pendingReg(pendingReg), .enableView(enableView), .gieOut(gieOut),
    .pieOut(pieOut), .privPrevOut(privPrevOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench model built from the requirements
  function automatic logic [31:0] liveVector();
    logic [31:0] v = '0;
    v[3] = swReq; v[7] = timerReq; v[11] = extReq;
    for (int i = 0; i < 15; i++) v[16+i] = fastReq[i];
    v[31] = nmiReq;
    return v;
  endfunction

  function automatic int topIndex(input logic [31:0] v);
    int w = -1;
    for (int i = 0; i < 32; i++) if (v[i]) w = i;
    return w;
  endfunction

  logic [31:0] mReq, mCause;
  logic        mGie, mPie, mInH, mTake, mValid = 1'b0;
  logic [1:0]  mPp;

  always @(posedge clk) begin : modelStep
    logic [31:0] cand;
    int          w;
    cand = {mReq[31], mReq[30:0] & enableIn[30:0] & {31{mGie}}};
    w    = topIndex(cand);
    if (!rstN) begin
      mReq <= '0; mCause <= '0; mGie <= 1'b0; mPie <= 1'b0;
      mInH <= 1'b0; mTake <= 1'b0; mPp <= 2'b11; mValid <= 1'b1;
    end else begin
      mReq <= liveVector();
      if (w >= 0 && !mInH && !retStrobe) begin
        mTake <= 1'b1; mCause <= 32'h8000_0000 | w; mGie <= 1'b0;
        mPie <= 1'b1; mPp <= 2'b11; mInH <= 1'b1;
      end else begin
        mTake <= 1'b0;
        if (retStrobe) begin
          mGie <= mPie; mPie <= 1'b1;
          if (mPie) mInH <= 1'b0;
        end else if (setGie) begin
          mGie <= 1'b1; mInH <= 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (mValid && !done) begin
      check("R1 pending vector", pendingReg, mReq & 32'h7FFF_FFFF);
      check("R2 enable view", enableView, enableIn & 32'h7FFF_FFFF);
      check("R8 trap pulse", {31'd0, takeTrap}, {31'd0, mTake});
      check("R6 cause word", causeWord, mCause);
      check("R7 status fields", {28'd0, gieOut, pieOut, privPrevOut},
            {28'd0, mGie, mPie, mPp});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dropLines();
    swReq = 0; timerReq = 0; extReq = 0; nmiReq = 0; fastReq = '0;
  endtask

  task automatic finishTrap();
    dropLines();
    step(1);
    retStrobe = 1;
    step(1);
    retStrobe = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    step(3);
    check("R11 reset gie/pie/priv", {29'd0, gieOut, pieOut, 1'b0}, 32'd0);
    check("R11 reset priv", {30'd0, privPrevOut}, 32'd3);
    check("R11 reset cause", causeWord, 32'd0);
    rstN = 1;

    // R5: masked external request with global enable 0 must not trap
    enableIn = 32'hFFFF_FFFF; extReq = 1;
    step(1);
    check("R1 external at bit 11", pendingReg, 32'h0000_0800);
    for (int k = 0; k < 3; k++) begin
      step(1);
      check("R5 no trap while gie=0", {31'd0, takeTrap}, 32'd0);
    end
    // R5: non-maskable bypasses the global enable
    nmiReq = 1;
    step(2);
    check("R5 nmi trap taken", {31'd0, takeTrap}, 32'd1);
    check("R6 nmi cause", causeWord, 32'h8000_001F);
    check("R7 entry fields", {29'd0, gieOut, pieOut, privPrevOut}, 32'h0000_0003 | 32'h4 >> 2 << 2 & 32'h4 | 32'h3);
    step(1);
    check("R8 pulse lasts one cycle", {31'd0, takeTrap}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      step(1);
      check("R8 no re-entry with line held", {31'd0, takeTrap}, 32'd0);
    end
    finishTrap();
    check("R9 return restores gie", {30'd0, gieOut, pieOut}, 32'd3);

    // R3: highest index wins
    swReq = 1; timerReq = 1; extReq = 1; fastReq = 15'h0001;
    step(2);
    check("R3 fast line 0 beats lower lines", causeWord, 32'h8000_0010);
    finishTrap();

    // R4: enable gating picks a lower winner
    enableIn = 32'h0000_0088; swReq = 1; timerReq = 1; extReq = 1;
    step(2);
    check("R4 disabled external skipped", causeWord, 32'h8000_0007);
    check("R4 trap taken", {31'd0, takeTrap}, 32'd1);
    finishTrap();
    enableIn = 32'h0; swReq = 1;
    step(3);
    check("R4 no trap with enable clear", {31'd0, takeTrap}, 32'd0);
    dropLines();

    // R10: set-enable re-arms after a trap without return
    enableIn = 32'hFFFF_FFFF; swReq = 1;
    step(2);
    check("R10 setup trap", causeWord, 32'h8000_0003);
    dropLines();
    step(1);
    check("R10 gie cleared by trap", {31'd0, gieOut}, 32'd0);
    setGie = 1;
    step(1);
    setGie = 0;
    check("R10 set-enable sets gie", {31'd0, gieOut}, 32'd1);
    timerReq = 1;
    step(2);
    check("R10 re-armed trap", causeWord, 32'h8000_0007);
    finishTrap();

    // R9: return beats a trap on the same edge
    fastReq = 15'h4000;
    step(1);
    retStrobe = 1;
    step(1);
    retStrobe = 0;
    check("R9 no trap on return edge", {31'd0, takeTrap}, 32'd0);
    step(1);
    check("R9 trap follows return", causeWord, 32'h8000_001E);
    finishTrap();

    // R2: non-maskable shows in neither view
    enableIn = 32'hFFFF_FFFF; nmiReq = 1;
    step(1);
    check("R2 pending bit 31 zero", pendingReg, 32'd0);
    check("R2 enable bit 31 zero", enableView, 32'h7FFF_FFFF);
    step(1);
    check("R3 nmi wins", causeWord, 32'h8000_001F);
    finishTrap();

    // Random phase checked by the model
    for (int c = 0; c < 3000; c++) begin
      swReq     = ($urandom % 8) == 0;
      timerReq  = ($urandom % 8) == 0;
      extReq    = ($urandom % 8) == 0;
      nmiReq    = ($urandom % 32) == 0;
      fastReq   = 15'($urandom & $urandom & $urandom);
      enableIn  = $urandom;
      retStrobe = ($urandom % 12) == 0;
      setGie    = ($urandom % 12) == 0;
      step(1);
    end
    dropLines(); retStrobe = 0; setGie = 0;
    rstN = 0;
    step(2);
    check("R11 reset after activity", {29'd0, gieOut, pieOut, takeTrap}, 32'd0);
    check("R11 reset cause", causeWord, 32'd0);
    check("R11 reset pending", pendingReg, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule